// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a synchronous host and an external asynchronous static RAM of 256K words by 16 bits. The host offers one request at a time: a word address, write data, a two-bit lane mask and a read/write flag. The request is accepted on the clock edge where valid and ready are both high. The controller then sequences the memory's chip-select, write strobe, output enable and two active-low lane enables. It also drives a split data bus made of an output word, an output-enable flag and an input word.

Every memory timing minimum is given in nanoseconds and converted to whole clock cycles by rounding up against the clock-period parameter `CLK_NS`. A write ends when the write strobe rises, and the chip-select and lane enables rise on the same edge. The data drivers switch on one cycle after the strobe falls and switch off one cycle after it rises. Read data is captured when the longest access delay has elapsed and is returned with a one-cycle valid pulse. A lane that is not requested reads as zero. After reset the controller waits out the supply-settling time (200 us) before it accepts any request.

With the defaults (`CLK_NS`=10) the derived counts are as follows:

| Count | Cycles |
|---|---|
| Power-up wait | 20000 |
| Write strobe low | 4 |
| Write cycle | 5 |
| Read access | 5 |

Top module: `sram_ctrl`

## Requirements
- R1: From reset release, `req_ready` stays low for exactly PWRUP_CYC = ceil(200000/CLK_NS) cycles. During reset and this wait, `mem_ce_n`, `mem_we_n` and `mem_oe_n` stay high and `mem_dq_oe` stays low.
- R2: A write changes only the lanes selected by the mask. Mask bit 0 selects bits 7:0 through `mem_lb_n` low, and mask bit 1 selects bits 15:8 through `mem_ub_n` low. Unselected lanes keep their old contents.
- R3: `mem_we_n` is low for exactly WLOW_CYC = max(ceil(35/CLK_NS), ceil(25/CLK_NS)+1, ceil(40/CLK_NS)) cycles per write. Throughout that time, `mem_ce_n` is low, at least one lane enable is low and `mem_oe_n` is high.
- R4: `mem_dq_oe` rises only while `mem_we_n` has already been low for a cycle. It falls one cycle after `mem_we_n` rises, and it is never high while `mem_oe_n` is low.
- R5: A write with a nonzero mask holds `req_ready` low for WC_CYC = ceil(45/CLK_NS) cycles after acceptance.
- R6: For a read with a nonzero mask, `mem_ce_n` and `mem_oe_n` are low with `mem_we_n` high for RD_CYC = max(ceil(45/CLK_NS), ceil(25/CLK_NS)) cycles. `rd_valid` is then high for one cycle, RD_CYC cycles after acceptance. `rd_data` carries the selected lanes, and unselected lanes read as zero.
- R7: A request with mask 00 is accepted without any chip-select or strobe. A write of this kind changes nothing. A read of this kind returns `rd_valid` with zero data in the cycle right after acceptance.
- R8: While `mem_ce_n` stays low, `mem_addr` and both lane enables remain stable.
- R9: `req_ready` is low while any memory access is in progress. A request is taken only on an edge where `req_valid` and `req_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select, bit 0 low byte, bit 1 high byte |
| rd_valid | output | 1 | One-cycle read-data strobe |
| rd_data | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 18 | Memory address |
| mem_ce_n | output | 1 | Chip-select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |
| mem_lb_n | output | 1 | Lower lane enable, active low |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 16 | Data returned by the memory |

## Verification
The properties assume that the host holds `req_write`, `req_addr`, `req_wdata` and `req_mask` steady from the raising of `req_valid` until acceptance. They also assume that `mem_dq_in` carries the memory's answer within the same cycle while the read controls are applied. The bench drives its requests only at falling clock edges and drops `req_valid` right after the accepting edge. A small byte-lane memory model answers reads combinationally and puts a marker value on any disabled lane, so a lane that is not zeroed shows up in the comparison. Addresses are restricted to the sixteen words the model keeps, with a high address bit set so that the full address width is exercised.

// File: rtl/sram_ctrl_pkg.sv
// Shared state type and cycle-conversion helpers for the SRAM controller.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_IDLE,
        ST_WR_LOW,
        ST_WR_REC,
        ST_RD_ACC
    } ctl_state_t;

    // Round a nanosecond figure up to whole clock cycles.
    function automatic int cyc_ceil(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
// Phase timer: loading N-1 makes the current phase last N cycles, and
// 'expired' is high in the last cycle. The reset value times the power-up
// wait. Assumes the FSM loads it only on phase changes.
module sram_wait_timer #(
    parameter int W       = 16,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    // Count down toward zero, reload on request.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= W'(RST_VAL);
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sram_read_capture.sv
// Read-data register: on 'capture' each lane takes the memory value if its
// mask bit is set, else zero; rd_valid pulses for the cycle after.
module sram_read_capture #(
    parameter int LANES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 capture,
    input  logic [LANES-1:0]     cap_mask,
    input  logic [8*LANES-1:0]   dq_in,
    output logic                 rd_valid,
    output logic [8*LANES-1:0]   rd_data
);
    // One-cycle strobe accompanying new data.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid <= 1'b0;
        else        rd_valid <= capture;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Per-lane capture with zeroing of unselected lanes.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rd_data[8*i +: 8] <= 8'h00;
            else if (capture)
                rd_data[8*i +: 8] <= cap_mask[i] ? dq_in[8*i +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/sram_ctrl.sv
// Byte-lane asynchronous SRAM controller. Sequences chip-select, write
// strobe, output enable and lane enables from cycle counts derived from
// nanosecond minimums. Assumes host request fields are stable while
// req_valid is high and that the memory answers reads within the access
// time. All memory-side outputs are registered.
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int CLK_NS     = 10,
    parameter int ADDR_W     = 18,
    parameter int DATA_W     = 16,
    parameter int T_WC_NS    = 45,
    parameter int T_PWE_NS   = 35,
    parameter int T_SD_NS    = 25,
    parameter int T_AW_NS    = 40,
    parameter int T_RC_NS    = 45,
    parameter int T_AA_NS    = 45,
    parameter int T_OE_NS    = 25,
    parameter int T_PWRUP_NS = 200000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_mask,
    output logic                rd_valid,
    output logic [DATA_W-1:0]   rd_data,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_ce_n,
    output logic                mem_we_n,
    output logic                mem_oe_n,
    output logic                mem_ub_n,
    output logic                mem_lb_n,
    output logic [DATA_W-1:0]   mem_dq_out,
    output logic                mem_dq_oe,
    input  logic [DATA_W-1:0]   mem_dq_in
);
    localparam int LANES     = DATA_W / 8;
    localparam int WLOW_CYC  = imax(cyc_ceil(T_PWE_NS, CLK_NS),
                               imax(cyc_ceil(T_SD_NS, CLK_NS) + 1,
                                    cyc_ceil(T_AW_NS, CLK_NS)));
    localparam int WC_CYC    = cyc_ceil(T_WC_NS, CLK_NS);
    localparam int REC_CYC   = imax(1, WC_CYC - WLOW_CYC);
    localparam int RD_CYC    = imax(cyc_ceil(T_RC_NS, CLK_NS),
                               imax(cyc_ceil(T_AA_NS, CLK_NS),
                                    cyc_ceil(T_OE_NS, CLK_NS)));
    localparam int PWRUP_CYC = imax(1, cyc_ceil(T_PWRUP_NS, CLK_NS));
    localparam int MAX_CYC   = imax(PWRUP_CYC, imax(WLOW_CYC, imax(REC_CYC, RD_CYC)));
    localparam int TW        = $clog2(MAX_CYC + 1);

    ctl_state_t        state;
    logic              accept;
    logic              tmr_load;
    logic [TW-1:0]     tmr_val;
    logic              tmr_expired;
    logic [LANES-1:0]  be_n;
    logic              capture;
    logic [LANES-1:0]  cap_mask;
    logic              in_pwrup;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign in_pwrup  = (state == ST_PWRUP);
    assign mem_ub_n  = be_n[LANES-1];
    assign mem_lb_n  = be_n[0];

    // Choose the length of the phase being entered.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state)
            ST_IDLE: if (accept && (req_mask != '0)) begin
                tmr_load = 1'b1;
                tmr_val  = req_write ? TW'(WLOW_CYC - 1) : TW'(RD_CYC - 1);
            end
            ST_WR_LOW: if (tmr_expired) begin
                tmr_load = 1'b1;
                tmr_val  = TW'(REC_CYC - 1);
            end
            default: ;
        endcase
    end

    sram_wait_timer #(.W(TW), .RST_VAL(PWRUP_CYC - 1)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    // Control sequencer and registered memory-side outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_PWRUP;
            mem_addr   <= '0;
            mem_ce_n   <= 1'b1;
            mem_we_n   <= 1'b1;
            mem_oe_n   <= 1'b1;
            be_n       <= '1;
            mem_dq_oe  <= 1'b0;
            mem_dq_out <= '0;
        end else begin
            case (state)
                ST_PWRUP: if (tmr_expired) state <= ST_IDLE;
                ST_IDLE: if (accept && (req_mask != '0)) begin
                    mem_addr <= req_addr;
                    mem_ce_n <= 1'b0;
                    be_n     <= ~req_mask;
                    if (req_write) begin
                        mem_we_n   <= 1'b0;
                        mem_dq_out <= req_wdata;
                        state      <= ST_WR_LOW;
                    end else begin
                        mem_oe_n <= 1'b0;
                        state    <= ST_RD_ACC;
                    end
                end
                ST_WR_LOW: begin
                    mem_dq_oe <= 1'b1;
                    if (tmr_expired) begin
                        mem_we_n <= 1'b1;
                        mem_ce_n <= 1'b1;
                        be_n     <= '1;
                        state    <= ST_WR_REC;
                    end
                end
                ST_WR_REC: begin
                    mem_dq_oe <= 1'b0;
                    if (tmr_expired) state <= ST_IDLE;
                end
                ST_RD_ACC: if (tmr_expired) begin
                    mem_ce_n <= 1'b1;
                    mem_oe_n <= 1'b1;
                    be_n     <= '1;
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Capture at the end of a read, or at once for an all-lanes-off read.
    assign capture  = ((state == ST_RD_ACC) && tmr_expired)
                    || (accept && !req_write && (req_mask == '0));
    assign cap_mask = (state == ST_RD_ACC) ? ~be_n : '0;

    sram_read_capture #(.LANES(LANES)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .cap_mask (cap_mask),
        .dq_in    (mem_dq_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/sram_ctrl_checker.sv
// Protocol checker for sram_ctrl, bound into every instance. Assumes the
// WLOW parameter equals the controller's derived strobe length.
module sram_ctrl_checker #(
    parameter int ADDR_W = 18,
    parameter int WLOW   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_pwrup,
    input logic              req_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_ub_n,
    input logic              mem_lb_n,
    input logic              mem_dq_oe
);
    logic [15:0] we_low_cnt;

    // Length of the current write-strobe low run.
    always_ff @(posedge clk) begin
        if (!rst_n)         we_low_cnt <= '0;
        else if (!mem_we_n) we_low_cnt <= we_low_cnt + 1'b1;
        else                we_low_cnt <= '0;
    end

    assert_pwrup_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_pwrup |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

    assert_we_qualified_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && !(mem_ub_n && mem_lb_n) && mem_oe_n));

    assert_we_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_cnt == 16'(WLOW)));

    assert_drive_after_we_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (!mem_we_n && $past(!mem_we_n)));

    assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |=> !mem_dq_oe);

    assert_no_contention_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    assert_read_ctrl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_ce_n && mem_we_n));

    assert_addr_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable({mem_ub_n, mem_lb_n})));

    assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !req_ready);
endmodule

bind sram_ctrl sram_ctrl_checker #(.ADDR_W(ADDR_W), .WLOW(WLOW_CYC)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_pwrup  (in_pwrup),
    .req_ready (req_ready),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_ub_n  (mem_ub_n),
    .mem_lb_n  (mem_lb_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_ctrl_test.sv
// Bench: sram_ctrl against a 16-word byte-lane memory model.
module sram_ctrl_test;
    localparam int CLK_NS    = 10;
    localparam int PWRUP_CYC = (200000 + CLK_NS - 1) / CLK_NS;
    localparam int WC        = (45 + CLK_NS - 1) / CLK_NS;
    localparam int RD        = (45 + CLK_NS - 1) / CLK_NS;
    localparam int SD1       = (25 + CLK_NS - 1) / CLK_NS + 1;
    localparam int PWE       = (35 + CLK_NS - 1) / CLK_NS;
    localparam int AW        = (40 + CLK_NS - 1) / CLK_NS;
    localparam int WLOW      = (PWE > SD1) ? ((PWE > AW) ? PWE : AW) : ((SD1 > AW) ? SD1 : AW);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic [17:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in;

    int nchk = 0;
    int nerr = 0;
    int strobes = 0;
    int lowrun = 0;
    bit pw_done = 1'b0;
    logic prev_ce_n = 1'b1;
    logic prev_we_n = 1'b1;
    logic prev_dq_oe = 1'b0;
    logic [15:0] model [16];
    logic [15:0] sh [16];

    always #(CLK_NS/2) clk = ~clk;

    sram_ctrl #(.CLK_NS(CLK_NS)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory model: answers reads combinationally, marks disabled lanes.
    always_comb begin
        if (!mem_ce_n && !mem_oe_n && mem_we_n)
            mem_dq_in = {mem_ub_n ? 8'hEE : model[mem_addr[3:0]][15:8],
                         mem_lb_n ? 8'hEE : model[mem_addr[3:0]][7:0]};
        else
            mem_dq_in = 16'hBEEF;
    end

    // Memory model write port and protocol monitor.
    always @(negedge clk) begin
        if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
            if (!mem_lb_n) model[mem_addr[3:0]][7:0]  <= mem_dq_out[7:0];
            if (!mem_ub_n) model[mem_addr[3:0]][15:8] <= mem_dq_out[15:8];
        end
        if (req_ready) pw_done = 1'b1;
        if (!pw_done && (!mem_ce_n || !mem_we_n || !mem_oe_n || mem_dq_oe))
            chk(1'b0, "R1 strobe during power-up", 1, 0);
        if (prev_ce_n && !mem_ce_n) strobes++;
        if (!mem_we_n) lowrun++;
        else if (lowrun != 0) begin
            chk(lowrun == WLOW, "R3 write strobe width", lowrun, WLOW);
            lowrun = 0;
        end
        if (mem_dq_oe && !mem_oe_n) chk(1'b0, "R4 bus contention", 1, 0);
        if (mem_dq_oe && !prev_dq_oe) chk(!prev_we_n && !mem_we_n, "R4 driver on before strobe", 0, 1);
        if (!mem_dq_oe && prev_dq_oe) chk(prev_we_n, "R4 driver released late", 0, 1);
        prev_ce_n  = mem_ce_n;
        prev_we_n  = mem_we_n;
        prev_dq_oe = mem_dq_oe;
    end

    // Present one request; returns at the falling edge after acceptance.
    task automatic issue(input logic w, input int a, input logic [15:0] d, input logic [1:0] m);
        req_valid = 1'b1;
        req_write = w;
        req_addr  = {1'b1, 13'b0, 4'(a)};
        req_wdata = d;
        req_mask  = m;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_write(input int a, input logic [15:0] d, input logic [1:0] m);
        int n = 0;
        int s0 = strobes;
        issue(1'b1, a, d, m);
        while (!req_ready) begin @(negedge clk); n++; end
        if (m != 2'b00) chk(n == WC, "R5 R9 write busy cycles", n, WC);
        else            chk(n == 0 && strobes == s0, "R7 masked-off write strobes", strobes - s0, 0);
        if (m[0]) sh[a][7:0]  = d[7:0];
        if (m[1]) sh[a][15:8] = d[15:8];
    endtask

    task automatic do_read(input int a, input logic [1:0] m);
        int n = 0;
        int s0 = strobes;
        logic [15:0] exp_d;
        issue(1'b0, a, 16'h0, m);
        while (!rd_valid) begin @(negedge clk); n++; end
        exp_d = {m[1] ? sh[a][15:8] : 8'h00, m[0] ? sh[a][7:0] : 8'h00};
        chk(rd_data == exp_d, "R2 R6 read data", rd_data, exp_d);
        if (m != 2'b00) chk(n == RD, "R6 read latency", n, RD);
        else            chk(n == 0 && strobes == s0, "R7 masked-off read", n, 0);
        @(negedge clk);
        chk(!rd_valid, "R6 valid single cycle", rd_valid, 0);
    endtask

    initial begin
        int n = 0;
        repeat (3) @(negedge clk);
        chk({mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rd_valid} == 6'b111000,
            "R1 reset state", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rd_valid}, 6'b111000);
        rst_n = 1'b1;
        while (!req_ready) begin @(negedge clk); n++; end
        chk(n == PWRUP_CYC, "R1 power-up wait", n, PWRUP_CYC);
        chk(strobes == 0, "R1 no strobe before ready", strobes, 0);
        for (int a = 0; a < 16; a++) do_write(a, 16'(a * 16'h0909 + 16'h1234), 2'b11);
        for (int a = 0; a < 16; a++) do_write(a, 16'((a * 16'h3C5A) ^ 16'hF00F), 2'(a % 4));
        for (int a = 0; a < 16; a++) do_read(a, 2'((a + 1) % 4));
        for (int a = 0; a < 16; a++) do_read(a, 2'b11);
        for (int a = 0; a < 16; a++) chk(model[a] == sh[a], "R2 lane contents", model[a], sh[a]);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule